// File: doc/BRIEF.md
# Self-Triggered Strip Hit Collector

This block collects hits from 128 binary discriminator channels without any trigger input. The channels form 16 groups of 8 strips. A hit strobe on a channel stores that channel's 3-bit amplitude together with the current value of a free-running 8-bit beam-crossing counter. The stored hit then waits as a pending entry until a record leaves the block through a valid/ready output.

The crossing counter advances on a base tick input. A 2-bit select sets the crossing period to 1, 2 or 3 base ticks. When more than one hit is pending, a fixed priority inside each group (lowest strip first) and a round-robin between groups set the output order. Each strip holds one pending hit. A strobe on a strip that is already pending is dropped and counted in a saturating counter.

Top module: `strip_hit_collector`

## Requirements
- R1: After synchronous reset `rec_valid` is 0, `bx_count` is 0 and `drop_count` is 0.
- R2: `bx_count` increases by one after every (`period_sel`+1) clock cycles in which `base_tick` is high, for `period_sel` 0, 1 and 2. The value 3 behaves like 2. The counter wraps from 255 to 0 and does not change when `base_tick` is low.
- R3: A one-cycle strobe on channel i (bit i of `hit_strobe`, amplitude at `hit_amp[3*i+2:3*i]`) whose strip is not pending produces exactly one record with `rec_group` = i/8, `rec_strip` = i%8 and `rec_amp` equal to the amplitude sampled with the strobe.
- R4: `rec_ts` equals the `bx_count` value present in the cycle the strobe was sampled.
- R5: Within one group, pending strips are sent from lowest strip number to highest.
- R6: Across groups, once a record from group g is accepted, the search for the next record starts at group g+1 (mod 16) and takes the first group that has a pending hit.
- R7: A strobe on a strip that is still pending is dropped. It leaves that strip's stored amplitude and time stamp unchanged, and `drop_count` grows by one for each dropped strobe.
- R8: `drop_count` saturates at 255.
- R9: While `rec_valid` is high and `rec_ready` is low, `rec_valid` and every record field stay unchanged, even when new hits arrive. A strip's pending entry clears only on the accepting handshake.
- R10: A strobe sampled at clock edge k on an idle block gives `rec_valid` high after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base crossing-period enable |
| period_sel | input | 2 | Base ticks per crossing minus one (0..2) |
| hit_strobe | input | 128 | Per-channel discriminator hit strobe |
| hit_amp | input | 384 | Per-channel 3-bit amplitude, channel i at bits 3i+2..3i |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted when high together with valid |
| rec_group | output | 5 | Group number of the record |
| rec_strip | output | 4 | Strip number within the group |
| rec_amp | output | 3 | Amplitude code |
| rec_ts | output | 8 | Crossing-count time stamp |
| bx_count | output | 8 | Current crossing count |
| drop_count | output | 8 | Saturating count of dropped strobes |

## Verification
The main function is driven first with single strobes on edge channels: the first and last strip of the first, middle and last groups. These separate errors in group and strip decoding and in amplitude lane selection. Next come simultaneous strobes inside one group, which show whether the priority order is right. Strobes spread over groups behind a moved round-robin pointer show whether the search starts after the last served group. A stalled output under repeated and lower-priority strobes separates drop counting, saturation and record stability from one another. Crossing-period runs at every select value and across the wrap check the time base that the time stamps depend on.

// File: rtl/shc_pkg.sv
package shc_pkg;
    localparam int N_GRP      = 16;
    localparam int GRP_SZ     = 8;
    localparam int AMP_W      = 3;
    localparam int TS_W       = 8;
    localparam int GRP_ID_W   = 5;
    localparam int STRIP_ID_W = 4;
    localparam int OVF_W      = 8;
    localparam int N_CH       = N_GRP * GRP_SZ;
    localparam int GSEL_W     = $clog2(N_GRP);
    localparam int SSEL_W     = $clog2(GRP_SZ);
    localparam int DCNT_W     = $clog2(GRP_SZ + 1);

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [TS_W-1:0]  ts;
    } hit_t;

    typedef struct packed {
        logic [GRP_ID_W-1:0]   grp;
        logic [STRIP_ID_W-1:0] strip;
        hit_t                  hit;
    } rec_t;

    // number of base ticks per crossing, minus one
    function automatic logic [1:0] period_limit(input logic [1:0] sel);
        return (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/shc_bx_counter.sv
module shc_bx_counter
    import shc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            base_tick,
    input  logic [1:0]      period_sel,
    output logic [TS_W-1:0] bx
);
    logic [1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            bx    <= '0;
        end else if (base_tick) begin
            if (div_q >= period_limit(period_sel)) begin
                div_q <= '0;
                bx    <= bx + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !base_tick |=> $stable(bx));
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        base_tick |=> (bx == $past(bx)) || (bx == $past(bx) + 1'b1));
endmodule

// File: rtl/shc_strip_group.sv
module shc_strip_group
    import shc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [GRP_SZ-1:0]       strobe,
    input  logic [GRP_SZ*AMP_W-1:0] amp,
    input  logic [TS_W-1:0]         ts_now,
    input  logic                    clr_en,
    input  logic [SSEL_W-1:0]       clr_idx,
    output logic                    any_pend,
    output logic [SSEL_W-1:0]       low_idx,
    output hit_t                    low_hit,
    output logic [DCNT_W-1:0]       drops
);
    logic [GRP_SZ-1:0] pend;
    hit_t              hits [GRP_SZ];

    for (genvar i = 0; i < GRP_SZ; i++) begin : g_strip
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
                hits[i] <= '0;
            end else if (strobe[i] && !pend[i]) begin
                pend[i]     <= 1'b1;
                hits[i].amp <= amp[i*AMP_W +: AMP_W];
                hits[i].ts  <= ts_now;
            end else if (clr_en && clr_idx == SSEL_W'(i)) begin
                pend[i] <= 1'b0;
            end
        end

        a_r7_drop_keeps: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && strobe[i]) |=> $stable(hits[i]));
    end

    always_comb begin
        low_idx = '0;
        for (int i = GRP_SZ - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = SSEL_W'(i);
        end
    end

    always_comb begin
        drops = '0;
        for (int i = 0; i < GRP_SZ; i++) begin
            drops = drops + DCNT_W'(strobe[i] && pend[i]);
        end
    end

    assign any_pend = |pend;
    assign low_hit  = hits[low_idx];

    a_r9_pend_held: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/shc_rr_pick.sv
module shc_rr_pick
    import shc_pkg::*;
(
    input  logic [N_GRP-1:0]  req,
    input  logic [GSEL_W-1:0] ptr,
    output logic              found,
    output logic [GSEL_W-1:0] gnt
);
    always_comb begin
        found = 1'b0;
        gnt   = '0;
        for (int k = N_GRP - 1; k >= 0; k--) begin
            if (req[(int'(ptr) + k) % N_GRP]) begin
                found = 1'b1;
                gnt   = GSEL_W'((int'(ptr) + k) % N_GRP);
            end
        end
    end
endmodule

// File: rtl/strip_hit_collector.sv
module strip_hit_collector
    import shc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    base_tick,
    input  logic [1:0]              period_sel,
    input  logic [N_CH-1:0]         hit_strobe,
    input  logic [N_CH*AMP_W-1:0]   hit_amp,
    output logic                    rec_valid,
    input  logic                    rec_ready,
    output logic [GRP_ID_W-1:0]     rec_group,
    output logic [STRIP_ID_W-1:0]   rec_strip,
    output logic [AMP_W-1:0]        rec_amp,
    output logic [TS_W-1:0]         rec_ts,
    output logic [TS_W-1:0]         bx_count,
    output logic [OVF_W-1:0]        drop_count
);
    localparam int SUM_W = $clog2(N_CH + 1);
    localparam int OVF_MAX = (1 << OVF_W) - 1;

    logic [N_GRP-1:0]  any_pend;
    logic [SSEL_W-1:0] low_idx [N_GRP];
    hit_t              low_hit [N_GRP];
    logic [DCNT_W-1:0] drops   [N_GRP];
    logic              busy;
    logic [GSEL_W-1:0] cur_g, ptr, gsel;
    logic              found;
    logic              accept;
    rec_t              rec_q;
    logic [SUM_W-1:0]  drop_sum;

    shc_bx_counter u_bx (
        .clk(clk), .rst(rst), .base_tick(base_tick),
        .period_sel(period_sel), .bx(bx_count)
    );

    assign accept = busy && rec_ready;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        shc_strip_group u_grp (
            .clk(clk), .rst(rst),
            .strobe(hit_strobe[g*GRP_SZ +: GRP_SZ]),
            .amp(hit_amp[g*GRP_SZ*AMP_W +: GRP_SZ*AMP_W]),
            .ts_now(bx_count),
            .clr_en(accept && cur_g == GSEL_W'(g)),
            .clr_idx(rec_q.strip[SSEL_W-1:0]),
            .any_pend(any_pend[g]),
            .low_idx(low_idx[g]),
            .low_hit(low_hit[g]),
            .drops(drops[g])
        );
    end

    shc_rr_pick u_rr (.req(any_pend), .ptr(ptr), .found(found), .gnt(gsel));

    always_comb begin
        drop_sum = '0;
        for (int g = 0; g < N_GRP; g++) drop_sum = drop_sum + SUM_W'(drops[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cur_g <= '0;
            ptr   <= '0;
            rec_q <= '0;
        end else if (busy) begin
            if (rec_ready) begin
                busy <= 1'b0;
                ptr  <= (cur_g == GSEL_W'(N_GRP - 1)) ? '0 : cur_g + 1'b1;
            end
        end else if (found) begin
            busy          <= 1'b1;
            cur_g         <= gsel;
            rec_q.grp     <= GRP_ID_W'(gsel);
            rec_q.strip   <= STRIP_ID_W'(low_idx[gsel]);
            rec_q.hit     <= low_hit[gsel];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_count <= '0;
        end else if (int'(drop_count) + int'(drop_sum) > OVF_MAX) begin
            drop_count <= OVF_W'(OVF_MAX);
        end else begin
            drop_count <= drop_count + OVF_W'(drop_sum);
        end
    end

    assign rec_valid = busy;
    assign rec_group = rec_q.grp;
    assign rec_strip = rec_q.strip;
    assign rec_amp   = rec_q.hit.amp;
    assign rec_ts    = rec_q.hit.ts;

    a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_group) &&
            $stable(rec_strip) && $stable(rec_amp) && $stable(rec_ts)));
    a_r8_ovf_sat: assert property (@(posedge clk) disable iff (rst)
        (drop_count == OVF_W'(OVF_MAX)) |=> (drop_count == OVF_W'(OVF_MAX)));
    a_r7_ovf_no_decrease: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count >= $past(drop_count)));
    a_r3_strip_range: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (int'(rec_strip) < GRP_SZ && int'(rec_group) < N_GRP));
    a_r10_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        (!rec_valid && any_pend == '0) |=> !rec_valid);
endmodule

// File: tb/strip_hit_collector_tb_top.sv
module strip_hit_collector_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         base_tick;
    logic [1:0]   period_sel;
    logic [127:0] hit_strobe;
    logic [383:0] hit_amp;
    logic         rec_valid, rec_ready;
    logic [4:0]   rec_group;
    logic [3:0]   rec_strip;
    logic [2:0]   rec_amp;
    logic [7:0]   rec_ts, bx_count, drop_count;

    int n_vec = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    strip_hit_collector dut_i (
        .clk(clk), .rst(rst), .base_tick(base_tick), .period_sel(period_sel),
        .hit_strobe(hit_strobe), .hit_amp(hit_amp),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_group(rec_group), .rec_strip(rec_strip), .rec_amp(rec_amp),
        .rec_ts(rec_ts), .bx_count(bx_count), .drop_count(drop_count)
    );

    // {channel[7:0], amplitude[2:0]}
    localparam logic [10:0] VEC [8] = '{
        {8'd0,   3'd5}, {8'd7,   3'd2}, {8'd8,   3'd7}, {8'd63,  3'd1},
        {8'd64,  3'd6}, {8'd119, 3'd3}, {8'd120, 3'd4}, {8'd127, 3'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; base_tick = 1'b0; period_sel = 2'd0;
        hit_strobe = '0; hit_amp = '0; rec_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_hit(input int ch, input logic [2:0] a);
        hit_strobe[ch] = 1'b1;
        hit_amp[ch*3 +: 3] = a;
    endtask

    task automatic strobe1(input int ch, input logic [2:0] a);
        set_hit(ch, a);
        @(negedge clk);
        hit_strobe = '0;
    endtask

    task automatic accept();
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
    endtask

    task automatic expect_rec(input string tag, input int g, input int s,
                              input int a, input int ts);
        for (int w = 0; w < 6 && !rec_valid; w++) @(negedge clk);
        eq({tag, " valid"}, int'(rec_valid), 1);
        eq({tag, " group"}, int'(rec_group), g);
        eq({tag, " strip"}, int'(rec_strip), s);
        eq({tag, " amp"},   int'(rec_amp), a);
        if (ts >= 0) eq({tag, " ts"}, int'(rec_ts), ts);
        accept();
    endtask

    task automatic ticks(input int n);
        base_tick = 1'b1;
        repeat (n) @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int bx_seen;
        do_reset();
        // R1 reset state
        eq("R1 valid", int'(rec_valid), 0);
        eq("R1 bx", int'(bx_count), 0);
        eq("R1 drops", int'(drop_count), 0);

        // R3 / R10 vector table
        for (int v = 0; v < 8; v++) begin
            int ch;
            ch = int'(VEC[v][10:3]);
            strobe1(ch, VEC[v][2:0]);
            eq("R10 not early", int'(rec_valid), 0);
            @(negedge clk);
            eq("R10 valid next", int'(rec_valid), 1);
            expect_rec("R3 vec", ch / 8, ch % 8, int'(VEC[v][2:0]), 0);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        eq("R3 single record", int'(rec_valid), 0);

        // R2 crossing periods and wrap
        do_reset();
        period_sel = 2'd1; ticks(10);
        eq("R2 sel1", int'(bx_count), 5);
        base_tick = 1'b0; repeat (4) @(negedge clk);
        eq("R2 idle", int'(bx_count), 5);
        period_sel = 2'd2; ticks(9);
        eq("R2 sel2", int'(bx_count), 8);
        period_sel = 2'd3; ticks(6);
        eq("R2 sel3", int'(bx_count), 10);
        period_sel = 2'd0; ticks(245);
        eq("R2 at top", int'(bx_count), 255);
        ticks(1);
        eq("R2 wrap", int'(bx_count), 0);

        // R4 time stamp at strobe cycle
        ticks(37);
        bx_seen = int'(bx_count);
        strobe1(90, 3'd6);
        ticks(20);
        expect_rec("R4", 11, 2, 6, bx_seen);

        // R5 priority inside one group
        do_reset();
        set_hit(22, 3'd1); set_hit(17, 3'd2); set_hit(18, 3'd3);
        @(negedge clk); hit_strobe = '0;
        expect_rec("R5 first", 2, 1, 2, -1);
        expect_rec("R5 second", 2, 2, 3, -1);
        expect_rec("R5 third", 2, 6, 1, -1);

        // R6 round robin from group after last served
        do_reset();
        strobe1(40, 3'd1);
        expect_rec("R6 prime", 5, 0, 1, -1);
        set_hit(24, 3'd3); set_hit(72, 3'd4); set_hit(48, 3'd5);
        @(negedge clk); hit_strobe = '0;
        expect_rec("R6 first", 6, 0, 5, -1);
        expect_rec("R6 second", 9, 0, 4, -1);
        expect_rec("R6 third", 3, 0, 3, -1);

        // R7 / R8 / R9 drops under a stalled output
        do_reset();
        strobe1(5, 3'd2);
        @(negedge clk);
        hit_strobe[5] = 1'b1; hit_amp[15 +: 3] = 3'd7;
        repeat (3) @(negedge clk);
        hit_strobe = '0;
        eq("R7 drop count", int'(drop_count), 3);
        strobe1(2, 3'd4);
        repeat (2) @(negedge clk);
        eq("R9 held valid", int'(rec_valid), 1);
        eq("R9 held strip", int'(rec_strip), 5);
        hit_strobe[5] = 1'b1;
        repeat (300) @(negedge clk);
        hit_strobe = '0;
        eq("R8 saturate", int'(drop_count), 255);
        expect_rec("R7 kept data", 0, 5, 2, 0);
        expect_rec("R9 after accept", 0, 2, 4, 0);
        repeat (3) @(negedge clk);
        eq("R9 drained", int'(rec_valid), 0);

        done = 1;
        finish_run();
    end
endmodule